// File: doc/BRIEF.md
# Draw Vertex Index Sequencer

This block produces the ordered list of vertex numbers for one draw call in a geometry front end. Software programs a handful of configuration words through a simple word-addressed write port (vertex count, first-vertex number, attribute base address, index-array location and index width). It then writes one of two trigger words. One trigger starts a linear draw and the other starts an indexed draw.

A linear draw counts upward from the programmed first vertex. An indexed draw reads 8-bit or 16-bit index values from memory through a byte-wide read port and emits them in array order. Each vertex number leaves on a valid/ready stream. An index of all ones is passed through unchanged, with a sideband bit raised so that a later stage can decide what it means. A one-cycle completion pulse marks the end of every draw, including a draw with a count of zero. A busy output shows when a draw is in progress.

Top module: `dvs_draw_sequencer`

## Requirements
- R1: Configuration words are written at these word addresses. Address 0x200 holds the attribute base in bits 28:0. Address 0x227 holds the index byte offset in bits 30:0 and the index width in bit 31 (0 = 8-bit, 1 = 16-bit). Address 0x228 holds the vertex count. Address 0x22a holds the first-vertex number. Writes to any other non-trigger address change nothing.
- R2: A write to address 0x22e starts a linear draw. It emits first+0, first+1, ... first+count-1 (modulo 2^32) in order, with the restart bit low.
- R3: A write to address 0x22f starts an indexed draw. It emits `count` fetched index values in array order, zero-extended to 32 bits. The first-vertex number is ignored.
- R4: Index element i is read starting at byte address base*8 + offset + i for 8-bit indices, or base*8 + offset + 2*i for 16-bit indices. A 16-bit index is little-endian: its low byte is at the lower address. The read port returns the addressed byte in the cycle after the cycle in which the read enable is high. No read is issued while the block is idle.
- R5: In an indexed draw, the restart bit is high with a value exactly when that value is all ones for the selected width (0xFF for 8-bit, 0xFFFF for 16-bit). The value itself is still emitted.
- R6: A trigger with a count of zero emits nothing. The done pulse is high in the cycle after the trigger write.
- R7: The done pulse lasts one cycle and comes in the cycle after the final stream handshake. Busy is high from the cycle after an accepted nonzero trigger until that done cycle, in which busy is already low.
- R8: A trigger write while busy is high is ignored: no extra vertices and no extra done pulse follow.
- R9: Configuration writes while busy is high do not change the draw in progress.
- R10: While valid is high and ready is low, valid stays high and the vertex number and restart bit stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | REG_AW | Word address of the write |
| wr_data | input | 32 | Write data |
| mem_rd_en | output | 1 | Byte read request |
| mem_rd_addr | output | ADDR_W | Byte address of the read |
| mem_rd_data | input | 8 | Byte returned one cycle after the request |
| vtx_valid | output | 1 | Vertex number valid |
| vtx_ready | input | 1 | Downstream accepts the vertex |
| vtx_num | output | 32 | Vertex number |
| vtx_restart | output | 1 | Value is the all-ones index marker |
| draw_done | output | 1 | One-cycle draw completion pulse |
| busy | output | 1 | Draw in progress |

## Verification
The bench builds the block with its default parameters: a 10-bit register word address, 32-bit byte addresses and a 32-bit vertex counter. The full-width counter allows first-vertex values just below 2^32, so a linear draw that wraps through zero can be checked. The bench memory decodes the low ten address bits, so random bases and offsets wrap within it, while the index elements planted at fixed addresses produce the 8-bit and 16-bit all-ones markers as well as 0x00FF, which must not be flagged. Random backpressure on ready exercises the hold rule, and writes injected mid-draw cover both the ignored trigger and the frozen configuration.

// File: rtl/dvs_pkg.sv
package dvs_pkg;
  localparam int WORD_W = 32;
  localparam int IDX_W  = 16;

  localparam int RA_BASE   = 'h200;
  localparam int RA_IDXCFG = 'h227;
  localparam int RA_COUNT  = 'h228;
  localparam int RA_FIRST  = 'h22a;
  localparam int RA_GO_LIN = 'h22e;
  localparam int RA_GO_IDX = 'h22f;

  // Byte address of index element n.
  function automatic logic [31:0] elem_byte_addr(input logic [28:0] base,
                                                 input logic [30:0] off,
                                                 input logic        wide,
                                                 input logic [31:0] n);
    logic [31:0] step;
    step = wide ? {n[30:0], 1'b0} : n;
    return {base, 3'b000} + {1'b0, off} + step;
  endfunction

  // Vertex number emitted at position n of a linear draw.
  function automatic logic [31:0] linear_vertex(input logic [31:0] first,
                                                input logic [31:0] n);
    return first + n;
  endfunction

  // All-ones marker for the selected index width.
  function automatic logic restart_mark(input logic [15:0] v, input logic wide);
    return wide ? (v == 16'hFFFF) : (v[7:0] == 8'hFF);
  endfunction
endpackage

// File: rtl/dvs_cfg_regs.sv
module dvs_cfg_regs #(
  parameter int REG_AW = 10,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic [28:0]       cfg_base,
  output logic [30:0]       cfg_off,
  output logic              cfg_wide,
  output logic [CNT_W-1:0]  cfg_count,
  output logic [31:0]       cfg_first,
  output logic              go_lin,
  output logic              go_idx
);
  import dvs_pkg::*;

  logic hit_base, hit_idx, hit_cnt, hit_first;

  assign hit_base  = wr_en && (wr_addr == REG_AW'(RA_BASE));
  assign hit_idx   = wr_en && (wr_addr == REG_AW'(RA_IDXCFG));
  assign hit_cnt   = wr_en && (wr_addr == REG_AW'(RA_COUNT));
  assign hit_first = wr_en && (wr_addr == REG_AW'(RA_FIRST));
  assign go_lin    = wr_en && (wr_addr == REG_AW'(RA_GO_LIN));
  assign go_idx    = wr_en && (wr_addr == REG_AW'(RA_GO_IDX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_base  <= '0;
      cfg_off   <= '0;
      cfg_wide  <= 1'b0;
      cfg_count <= '0;
      cfg_first <= '0;
    end else begin
      if (hit_base)  cfg_base  <= wr_data[28:0];
      if (hit_idx) begin
        cfg_off  <= wr_data[30:0];
        cfg_wide <= wr_data[31];
      end
      if (hit_cnt)   cfg_count <= CNT_W'(wr_data);
      if (hit_first) cfg_first <= wr_data;
    end
  end
endmodule

// File: rtl/dvs_index_fetch.sv
module dvs_index_fetch #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic              go_wide,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [7:0]        mem_rd_data,
  output logic              idx_ready,
  output logic [15:0]       idx_value
);
  typedef enum logic [1:0] {F_IDLE, F_RD0, F_CAP0, F_CAP1} fstate_t;

  fstate_t           st, st_nx;
  logic [ADDR_W-1:0] a_q;
  logic              wide_q;
  logic [7:0]        lo_q;

  always_comb begin
    st_nx       = st;
    mem_rd_en   = 1'b0;
    mem_rd_addr = a_q;
    idx_ready   = 1'b0;
    idx_value   = {8'h00, mem_rd_data};
    unique case (st)
      F_IDLE: if (go) st_nx = F_RD0;
      F_RD0: begin
        mem_rd_en = 1'b1;
        st_nx     = F_CAP0;
      end
      F_CAP0: begin
        if (wide_q) begin
          mem_rd_en   = 1'b1;
          mem_rd_addr = a_q + ADDR_W'(1);
          st_nx       = F_CAP1;
        end else begin
          idx_ready = 1'b1;
          st_nx     = F_IDLE;
        end
      end
      F_CAP1: begin
        idx_ready = 1'b1;
        idx_value = {mem_rd_data, lo_q};
        st_nx     = F_IDLE;
      end
      default: st_nx = F_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= F_IDLE;
      a_q    <= '0;
      wide_q <= 1'b0;
      lo_q   <= '0;
    end else begin
      st <= st_nx;
      if (st == F_IDLE && go) begin
        a_q    <= go_addr;
        wide_q <= go_wide;
      end
      if (st == F_CAP0) lo_q <= mem_rd_data;
    end
  end
endmodule

// File: rtl/dvs_draw_ctrl.sv
module dvs_draw_ctrl #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_lin,
  input  logic              go_idx,
  input  logic [28:0]       cfg_base,
  input  logic [30:0]       cfg_off,
  input  logic              cfg_wide,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic [31:0]       cfg_first,
  output logic              fetch_go,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_wide,
  input  logic              fetch_ready,
  input  logic [15:0]       fetch_value,
  output logic              vtx_valid,
  input  logic              vtx_ready,
  output logic [31:0]       vtx_num,
  output logic              vtx_restart,
  output logic              draw_done,
  output logic              busy,
  output logic              start_evt
);
  import dvs_pkg::*;

  typedef enum logic [2:0] {C_IDLE, C_LIN, C_FETCH, C_WAIT, C_EMIT} cstate_t;

  cstate_t          st;
  logic [CNT_W-1:0] run_cnt, pos_q;
  logic [28:0]      run_base;
  logic [30:0]      run_off;
  logic             run_wide;
  logic [31:0]      run_first;
  logic [15:0]      held_val;
  logic             held_rst;
  logic             done_q;
  logic             hs, last;

  assign start_evt  = (st == C_IDLE) && (go_lin || go_idx);
  assign hs         = vtx_valid && vtx_ready;
  assign last       = (pos_q == run_cnt - CNT_W'(1));
  assign busy       = (st != C_IDLE);
  assign draw_done  = done_q;

  assign fetch_go   = (st == C_FETCH);
  assign fetch_wide = run_wide;
  assign fetch_addr = ADDR_W'(elem_byte_addr(run_base, run_off, run_wide, 32'(pos_q)));

  assign vtx_valid   = (st == C_LIN) || (st == C_EMIT);
  assign vtx_num     = (st == C_LIN) ? linear_vertex(run_first, 32'(pos_q))
                                     : {16'h0000, held_val};
  assign vtx_restart = (st == C_EMIT) && held_rst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= C_IDLE;
      run_cnt   <= '0;
      pos_q     <= '0;
      run_base  <= '0;
      run_off   <= '0;
      run_wide  <= 1'b0;
      run_first <= '0;
      held_val  <= '0;
      held_rst  <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        C_IDLE: begin
          if (start_evt) begin
            if (cfg_count == '0) begin
              done_q <= 1'b1;
            end else begin
              run_cnt   <= cfg_count;
              run_base  <= cfg_base;
              run_off   <= cfg_off;
              run_wide  <= cfg_wide;
              run_first <= cfg_first;
              pos_q     <= '0;
              st        <= go_idx ? C_FETCH : C_LIN;
            end
          end
        end
        C_LIN: begin
          if (hs) begin
            if (last) begin
              st     <= C_IDLE;
              done_q <= 1'b1;
            end else begin
              pos_q <= pos_q + CNT_W'(1);
            end
          end
        end
        C_FETCH: st <= C_WAIT;
        C_WAIT: begin
          if (fetch_ready) begin
            held_val <= fetch_value;
            held_rst <= restart_mark(fetch_value, run_wide);
            st       <= C_EMIT;
          end
        end
        C_EMIT: begin
          if (hs) begin
            if (last) begin
              st     <= C_IDLE;
              done_q <= 1'b1;
            end else begin
              pos_q <= pos_q + CNT_W'(1);
              st    <= C_FETCH;
            end
          end
        end
        default: st <= C_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dvs_draw_sequencer.sv
module dvs_draw_sequencer #(
  parameter int REG_AW = 10,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [7:0]        mem_rd_data,
  output logic              vtx_valid,
  input  logic              vtx_ready,
  output logic [31:0]       vtx_num,
  output logic              vtx_restart,
  output logic              draw_done,
  output logic              busy
);
  logic [28:0]       cfg_base;
  logic [30:0]       cfg_off;
  logic              cfg_wide;
  logic [CNT_W-1:0]  cfg_count;
  logic [31:0]       cfg_first;
  logic              go_lin, go_idx;
  logic              fetch_go, fetch_wide, fetch_ready;
  logic [ADDR_W-1:0] fetch_addr;
  logic [15:0]       fetch_value;
  logic              start_evt;
  logic              trig_any;

  assign trig_any = go_lin || go_idx;

  dvs_cfg_regs #(.REG_AW(REG_AW), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_base(cfg_base), .cfg_off(cfg_off), .cfg_wide(cfg_wide),
    .cfg_count(cfg_count), .cfg_first(cfg_first), .go_lin(go_lin), .go_idx(go_idx)
  );

  dvs_draw_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .go_lin(go_lin), .go_idx(go_idx),
    .cfg_base(cfg_base), .cfg_off(cfg_off), .cfg_wide(cfg_wide),
    .cfg_count(cfg_count), .cfg_first(cfg_first),
    .fetch_go(fetch_go), .fetch_addr(fetch_addr), .fetch_wide(fetch_wide),
    .fetch_ready(fetch_ready), .fetch_value(fetch_value),
    .vtx_valid(vtx_valid), .vtx_ready(vtx_ready), .vtx_num(vtx_num),
    .vtx_restart(vtx_restart), .draw_done(draw_done), .busy(busy),
    .start_evt(start_evt)
  );

  dvs_index_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .go(fetch_go), .go_addr(fetch_addr),
    .go_wide(fetch_wide), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .idx_ready(fetch_ready), .idx_value(fetch_value)
  );
endmodule

// File: rtl/dvs_draw_sequencer_chk.sv
module dvs_draw_sequencer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        vtx_valid,
  input logic        vtx_ready,
  input logic [31:0] vtx_num,
  input logic        vtx_restart,
  input logic        draw_done,
  input logic        busy,
  input logic        mem_rd_en,
  input logic        start_evt,
  input logic        trig_any
);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (vtx_valid && !vtx_ready) |=> (vtx_valid && $stable(vtx_num) && $stable(vtx_restart)));

  assert_valid_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vtx_valid |-> busy);

  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    draw_done |-> (!busy && !vtx_valid));

  assert_start_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (busy || draw_done));

  assert_trig_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && trig_any) |-> !start_evt);

  assert_no_idle_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> busy);
endmodule

bind dvs_draw_sequencer dvs_draw_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .vtx_valid(vtx_valid), .vtx_ready(vtx_ready),
  .vtx_num(vtx_num), .vtx_restart(vtx_restart), .draw_done(draw_done),
  .busy(busy), .mem_rd_en(mem_rd_en), .start_evt(start_evt), .trig_any(trig_any)
);

// File: tb/tb_dvs_draw_sequencer.sv
`timescale 1ns/1ps
module tb_dvs_draw_sequencer;
  localparam logic [9:0] A_BASE = 10'h200, A_IDX = 10'h227, A_CNT = 10'h228,
                         A_FIRST = 10'h22a, A_LIN = 10'h22e, A_GOI = 10'h22f;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [9:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        mem_rd_en;
  logic [31:0] mem_rd_addr;
  logic [7:0]  mem_rd_data = '0;
  logic        vtx_valid, vtx_restart, draw_done, busy;
  logic        vtx_ready = 1'b0;
  logic [31:0] vtx_num;
  logic [7:0]  mem [0:1023];
  int          n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  dvs_draw_sequencer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .vtx_valid(vtx_valid), .vtx_ready(vtx_ready), .vtx_num(vtx_num),
    .vtx_restart(vtx_restart), .draw_done(draw_done), .busy(busy)
  );

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[9:0]];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Expected vertex number and marker, from the requirement text.
  function automatic logic [32:0] expect_vtx(input logic [31:0] base_w, input logic [31:0] icfg,
                                             input logic [31:0] first_w, input bit indexed,
                                             input int n);
    logic [31:0] a;
    logic [15:0] v;
    bit wide, mk;
    if (!indexed) return {1'b0, first_w + 32'(n)};
    wide = icfg[31];
    a = {base_w[28:0], 3'b000} + {1'b0, icfg[30:0]} + (wide ? 32'(2*n) : 32'(n));
    v = wide ? {mem[(a + 32'd1) & 32'h3ff], mem[a[9:0]]} : {8'h00, mem[a[9:0]]};
    mk = wide ? (v == 16'hFFFF) : (v[7:0] == 8'hFF);
    return {mk, 16'h0000, v};
  endfunction

  // mode 0: plain, 1: trigger injected mid-draw, 2: count rewrite mid-draw
  task automatic run_draw(input logic [31:0] base_w, input logic [31:0] icfg,
                          input logic [31:0] cnt, input logic [31:0] first_w,
                          input bit indexed, input int pct, input int mode);
    int got = 0;
    bit fin = 0;
    int cyc = 0;
    string rq;
    logic [32:0] e;
    rq = indexed ? "R3" : "R2";
    wr(A_BASE, base_w);
    wr(A_IDX, icfg);
    wr(A_CNT, cnt);
    wr(A_FIRST, first_w);
    wr(10'h229, 32'h0000_0000);  // R1: unmapped address, no effect
    wr(indexed ? A_GOI : A_LIN, 32'h0);
    if (cnt == 0) begin
      check(draw_done && !vtx_valid && !busy, "R6", "zero-count done/valid/busy",
            {draw_done, vtx_valid, busy}, 3'b100);
      @(negedge clk);
      check(!draw_done && !vtx_valid, "R6", "no output after zero draw",
            {draw_done, vtx_valid}, 2'b00);
      return;
    end
    check(busy && !draw_done, "R7", "busy after trigger", {busy, draw_done}, 2'b10);
    while (!fin && cyc < 4000) begin
      if (draw_done) begin
        fin = 1;
        check(!busy, "R7", "busy low in done cycle", busy, 0);
      end else begin
        wr_en = 1'b0;
        if (mode != 0 && cyc == 2) begin
          wr_en   = 1'b1;
          wr_addr = (mode == 1) ? (indexed ? A_LIN : A_GOI) : A_CNT;
          wr_data = 32'd2;
        end
        vtx_ready = ($urandom_range(0, 99) < pct);
        #1;
        if (vtx_valid && vtx_ready) begin
          e = expect_vtx(base_w, icfg, first_w, indexed, got);
          check(got < int'(cnt) && vtx_num == e[31:0],
                (mode == 2) ? "R9" : rq, "vertex number", vtx_num, e[31:0]);
          check(vtx_restart == e[32], indexed ? "R5" : "R2", "restart bit",
                vtx_restart, e[32]);
          got++;
        end
        @(negedge clk);
        cyc++;
      end
    end
    wr_en = 1'b0;
    check(fin, "R7", "done pulse seen", fin, 1);
    check(got == int'(cnt), (mode == 2) ? "R9" : rq, "vertex total", got, cnt);
    if (mode == 1) begin
      bit quiet = 1;
      vtx_ready = 1'b1;
      repeat (12) begin
        @(negedge clk);
        if (vtx_valid || draw_done || busy) quiet = 0;
      end
      check(quiet, "R8", "no activity from ignored trigger", !quiet, 0);
    end
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < 1024; k++) mem[k] = 8'($urandom);
    for (int k = 0; k < 1024; k++) if (mem[k] == 8'hFF) mem[k] = 8'h7E;
    mem[16] = 8'hFF; mem[17] = 8'hFF;   // 16-bit marker
    mem[40] = 8'hFF; mem[41] = 8'h00;   // 0x00FF: not a 16-bit marker
    mem[100] = 8'h34; mem[101] = 8'h12; // little-endian 0x1234

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !vtx_valid && !draw_done && !mem_rd_en, "R7", "reset state",
          {busy, vtx_valid, draw_done, mem_rd_en}, 0);

    run_draw(32'h0, 32'h0, 32'd5, 32'hFFFF_FFFE, 1'b0, 100, 0);             // R2 wrap
    run_draw(32'h0, 32'h0, 32'd0, 32'd7, 1'b0, 100, 0);                     // R6 linear
    run_draw(32'h0, 32'h0, 32'd0, 32'd7, 1'b1, 100, 0);                     // R6 indexed
    run_draw(32'd2, 32'h8000_0000, 32'd4, 32'd999, 1'b1, 50, 0);            // R5 16-bit
    run_draw(32'd5, 32'h8000_0000, 32'd2, 32'd0, 1'b1, 100, 0);             // R5 0x00FF
    run_draw(32'd5, 32'h0000_0000, 32'd3, 32'd50, 1'b1, 40, 0);             // R5 8-bit
    run_draw(32'hE000_000C, 32'h8000_0004, 32'd1, 32'd0, 1'b1, 100, 0);     // R1/R4 0x1234
    run_draw(32'd3, 32'h0000_0011, 32'd6, 32'd20, 1'b0, 30, 1);             // R8 linear
    run_draw(32'd3, 32'h8000_0011, 32'd6, 32'd20, 1'b1, 60, 1);             // R8 indexed
    run_draw(32'd9, 32'h0000_0002, 32'd7, 32'd300, 1'b1, 70, 2);            // R9
    run_draw(32'd9, 32'h0000_0002, 32'd7, 32'd300, 1'b0, 70, 2);            // R9

    for (int t = 0; t < 40; t++) begin
      int pct;
      pct = (t % 3 == 0) ? 100 : ((t % 3 == 1) ? 60 : 25);
      run_draw($urandom, {1'($urandom), 31'($urandom_range(0, 2000))},
               32'($urandom_range(0, 12)), $urandom, 1'($urandom), pct, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule